// File: doc/BRIEF.md
# Endian-Aware Memory Lane Steering

This block sits between a byte-addressed memory organised as 128-bit lines and a DSP core. It serves one instruction-fetch port and a parameterised number of data ports (two by default). A fetch always returns a whole 128-bit line as eight 16-bit instructions. A data access reads or writes a byte, a 16-bit word, a 32-bit long or a 64-bit four-word quantity. Read operands are returned right-justified on a 64-bit data bus.

A mode input selects little-endian or big-endian operation. The block moves byte lanes between the memory line and the core buses so that the core always sees the same layout. For fetches, big-endian mode reverses the order of the 16-bit instruction slots in the line and leaves the bytes inside each slot alone. For data, the mode decides where the operand sits inside the line and which byte of it is most significant. Writes use the same lane mapping in reverse and drive per-byte enables, so only the addressed bytes change. The memory itself is outside the block. The block drives the line indices and write strobes, and receives the line contents combinationally.

Top module: `endian_lane_steer`

## Requirements
- R1: A fetch request returns f_valid_o high exactly one cycle later, carrying the whole 128-bit line selected by the fetch address with its low 4 bits ignored.
- R2: The memory line layout depends on the mode. Little-endian puts byte offset k in line bits 8k+7:8k, and big-endian puts it in bits 8(15-k)+7:8(15-k). The fetched instruction i (i = 0..7) sits in f_insn_o bits 16i+15:16i and holds the 16-bit value at line offset 2i. That value is {byte 2i+1, byte 2i} in little-endian mode and {byte 2i, byte 2i+1} in big-endian mode.
- R3: An aligned read on a data bus raises that bus's valid one cycle after the request. The operand is right-justified, and the bits above the operand are zero. Size codes are 0 = byte, 1 = word (2 bytes), 2 = long (4 bytes), 3 = four-word (8 bytes).
- R4: In little-endian mode, a read of n bytes at address a places byte a+i in data bits 8i+7:8i.
- R5: In big-endian mode, a read of n bytes at address a places byte a+i in data bits 8(n-1-i)+7:8(n-1-i). For example, a long read at address 8 returns the word at 8 in bits 31:16, and a byte read at 8 returns the high-order byte of the word at 8.
- R6: In both modes, a word read at an even address returns the same 16-bit value as the fetch slot that covers that address.
- R7: A word access at an odd address, a long access not aligned to 4 bytes, or a four-word access not aligned to 8 bytes gives an error pulse one cycle later. It gives no valid pulse and makes no memory write.
- R8: An aligned write changes exactly the n addressed bytes. It uses the same byte placement as a read of the same mode, so reading back returns the written operand and every other byte keeps its value.
- R9: The mode input is captured only in a cycle with no request on any port and no response pending. A change made during back-to-back traffic takes effect only after such an idle cycle.
- R10: After reset, no valid or error output is high and the block is in little-endian mode until the mode is first captured.
- R11: The data buses work independently and at the same time, each with its own size, address, mode placement and response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian_i | input | 1 | Requested mode, 1 = big-endian |
| f_req_i | input | 1 | Fetch request |
| f_addr_i | input | AW | Fetch byte address (low 4 bits ignored) |
| f_valid_o | output | 1 | Fetch result valid |
| f_insn_o | output | INSN_W*NINSN | Eight packed instructions |
| d_req_i | input | NBUS | Data request per bus |
| d_we_i | input | NBUS | Write (1) or read (0) per bus |
| d_size_i | input | 2*NBUS | Size code per bus |
| d_addr_i | input | NBUS*AW | Byte address per bus |
| d_wdata_i | input | NBUS*DW | Right-justified write operand per bus |
| d_valid_o | output | NBUS | Read data valid per bus |
| d_err_o | output | NBUS | Alignment error pulse per bus |
| d_rdata_o | output | NBUS*DW | Right-justified read operand per bus |
| m_f_line_o | output | LA | Line index for the fetch read |
| m_f_rdata_i | input | LW | Line contents for the fetch read |
| m_d_line_o | output | NBUS*LA | Line index per data bus |
| m_d_rdata_i | input | NBUS*LW | Line contents per data bus |
| m_d_we_o | output | NBUS | Line write strobe per data bus |
| m_d_be_o | output | NBUS*LB | Byte enables per data bus |
| m_d_wdata_o | output | NBUS*LW | Lane-steered write data per data bus |

## Verification
The hardest situation to reach is a mode change that arrives while traffic is continuous. The new mode must stay unused until an idle cycle with no pending response, and from the ports a late mode looks like a plain data mismatch. A directed sequence keeps reads back-to-back while the mode input flips, then inserts idle cycles. The random phase toggles the mode at random points among mixed traffic, with idle gaps. Reads and writes on both buses share a few lines, including misaligned attempts, and the memory image is compared with a model at the end.

// File: rtl/elp_pkg.sv
package elp_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_QUAD = 2'd3
  } size_e;

  // operand length in bytes for a size code
  function automatic int size_bytes(input size_e sz);
    return 1 << int'(sz);
  endfunction

endpackage

// File: rtl/elp_mode_hold.sv
module elp_mode_hold (
  input  logic clk,
  input  logic rst,
  input  logic mode_i,
  input  logic any_req_i,
  input  logic any_pend_i,
  output logic mode_o
);

  // capture only when the block is completely quiet
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= 1'b0;
    end else if (!any_req_i && !any_pend_i) begin
      mode_o <= mode_i;
    end
  end

endmodule

// File: rtl/elp_fetch_path.sv
module elp_fetch_path #(
  parameter int INSN_W = 16,
  parameter int NINSN  = 8,
  localparam int LW    = INSN_W * NINSN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          big_i,
  input  logic          req_i,
  input  logic [LW-1:0] line_i,
  output logic          valid_o,
  output logic [LW-1:0] insn_o
);

  logic [LW-1:0] slot_rev;

  for (genvar j = 0; j < NINSN; j++) begin : g_slot
    assign slot_rev[j*INSN_W +: INSN_W] = line_i[(NINSN-1-j)*INSN_W +: INSN_W];
  end

  always_ff @(posedge clk) begin
    if (rst) valid_o <= 1'b0;
    else     valid_o <= req_i;
  end

  always_ff @(posedge clk) begin
    if (req_i) insn_o <= big_i ? slot_rev : line_i;
  end

endmodule

// File: rtl/elp_data_lane.sv
module elp_data_lane
  import elp_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 64,
  parameter int LW   = 128,
  localparam int LB   = LW / 8,
  localparam int OFFW = $clog2(LB),
  localparam int DB   = DW / 8,
  localparam int SHW  = OFFW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               big_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [1:0]         size_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [LW-1:0]      line_i,
  output logic [AW-OFFW-1:0] line_addr_o,
  output logic               mem_we_o,
  output logic [LB-1:0]      mem_be_o,
  output logic [LW-1:0]      mem_wdata_o,
  output logic               valid_o,
  output logic               err_o,
  output logic [DW-1:0]      rdata_o
);

  localparam logic [SHW-1:0] LBV = SHW'(LB);

  logic [OFFW-1:0] off;
  logic [SHW-1:0]  nbytes;
  logic [SHW-1:0]  lo;
  logic            misalign;
  logic [DB-1:0]   bmask;
  logic [DW-1:0]   opmask;
  logic [LW-1:0]   rd_shift;
  logic            unused_hi;

  assign off      = addr_i[OFFW-1:0];
  assign nbytes   = SHW'(size_bytes(size_e'(size_i)));
  assign misalign = |(off & (nbytes[OFFW-1:0] - OFFW'(1)));

  // lowest line lane of the operand: mirrored from the top in big-endian
  assign lo = big_i ? (LBV - {1'b0, off} - nbytes) : {1'b0, off};

  for (genvar b = 0; b < DB; b++) begin : g_byte
    assign bmask[b]            = SHW'(b) < nbytes;
    assign opmask[b*8 +: 8]    = {8{bmask[b]}};
  end

  assign rd_shift    = line_i >> {lo, 3'b000};
  assign unused_hi   = ^rd_shift[LW-1:DW];
  assign line_addr_o = addr_i[AW-1:OFFW];
  assign mem_we_o    = req_i & we_i & ~misalign;
  assign mem_be_o    = {{(LB-DB){1'b0}}, bmask} << lo;
  assign mem_wdata_o = {{(LW-DW){1'b0}}, wdata_i & opmask} << {lo, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= req_i & ~we_i & ~misalign;
      err_o   <= req_i & misalign;
    end
  end

  always_ff @(posedge clk) begin
    if (req_i && !we_i) rdata_o <= rd_shift[DW-1:0] & opmask;
  end

endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer #(
  parameter int AW     = 12,
  parameter int INSN_W = 16,
  parameter int NINSN  = 8,
  parameter int DW     = 64,
  parameter int NBUS   = 2,
  localparam int LW    = INSN_W * NINSN,
  localparam int LB    = LW / 8,
  localparam int OFFW  = $clog2(LB),
  localparam int LA    = AW - OFFW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               big_endian_i,
  input  logic               f_req_i,
  input  logic [AW-1:0]      f_addr_i,
  output logic               f_valid_o,
  output logic [LW-1:0]      f_insn_o,
  input  logic [NBUS-1:0]    d_req_i,
  input  logic [NBUS-1:0]    d_we_i,
  input  logic [2*NBUS-1:0]  d_size_i,
  input  logic [NBUS*AW-1:0] d_addr_i,
  input  logic [NBUS*DW-1:0] d_wdata_i,
  output logic [NBUS-1:0]    d_valid_o,
  output logic [NBUS-1:0]    d_err_o,
  output logic [NBUS*DW-1:0] d_rdata_o,
  output logic [LA-1:0]      m_f_line_o,
  input  logic [LW-1:0]      m_f_rdata_i,
  output logic [NBUS*LA-1:0] m_d_line_o,
  input  logic [NBUS*LW-1:0] m_d_rdata_i,
  output logic [NBUS-1:0]    m_d_we_o,
  output logic [NBUS*LB-1:0] m_d_be_o,
  output logic [NBUS*LW-1:0] m_d_wdata_o
);

  logic mode_q;
  logic any_req;
  logic any_pend;
  logic unused_fofs;

  assign any_req     = f_req_i | (|d_req_i);
  assign any_pend    = f_valid_o | (|d_valid_o) | (|d_err_o);
  assign m_f_line_o  = f_addr_i[AW-1:OFFW];
  assign unused_fofs = ^f_addr_i[OFFW-1:0];

  elp_mode_hold i_mode (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (big_endian_i),
    .any_req_i (any_req),
    .any_pend_i(any_pend),
    .mode_o    (mode_q)
  );

  elp_fetch_path #(.INSN_W(INSN_W), .NINSN(NINSN)) i_fetch (
    .clk    (clk),
    .rst    (rst),
    .big_i  (mode_q),
    .req_i  (f_req_i),
    .line_i (m_f_rdata_i),
    .valid_o(f_valid_o),
    .insn_o (f_insn_o)
  );

  for (genvar g = 0; g < NBUS; g++) begin : g_bus
    elp_data_lane #(.AW(AW), .DW(DW), .LW(LW)) i_lane (
      .clk        (clk),
      .rst        (rst),
      .big_i      (mode_q),
      .req_i      (d_req_i[g]),
      .we_i       (d_we_i[g]),
      .size_i     (d_size_i[2*g +: 2]),
      .addr_i     (d_addr_i[g*AW +: AW]),
      .wdata_i    (d_wdata_i[g*DW +: DW]),
      .line_i     (m_d_rdata_i[g*LW +: LW]),
      .line_addr_o(m_d_line_o[g*LA +: LA]),
      .mem_we_o   (m_d_we_o[g]),
      .mem_be_o   (m_d_be_o[g*LB +: LB]),
      .mem_wdata_o(m_d_wdata_o[g*LW +: LW]),
      .valid_o    (d_valid_o[g]),
      .err_o      (d_err_o[g]),
      .rdata_o    (d_rdata_o[g*DW +: DW])
    );
  end

endmodule

// File: rtl/elp_checker.sv
module elp_checker #(
  parameter int AW   = 12,
  parameter int NBUS = 2,
  parameter int LB   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               f_req_i,
  input logic               f_valid_o,
  input logic [NBUS-1:0]    d_req_i,
  input logic [NBUS-1:0]    d_we_i,
  input logic [2*NBUS-1:0]  d_size_i,
  input logic [NBUS*AW-1:0] d_addr_i,
  input logic [NBUS-1:0]    d_valid_o,
  input logic [NBUS-1:0]    d_err_o,
  input logic [NBUS-1:0]    m_d_we_o,
  input logic [NBUS*LB-1:0] m_d_be_o,
  input logic               mode_q
);

  logic any_req;
  assign any_req = f_req_i | (|d_req_i);

  // R1
  fetch_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    f_valid_o |-> $past(f_req_i));

  // R1
  fetch_valid_due_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(f_req_i) && !$past(rst)) |-> f_valid_o);

  // R9
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    any_req |=> $stable(mode_q));

  for (genvar g = 0; g < NBUS; g++) begin : g_bus
    logic [1:0] sz;
    logic [2:0] lowa;
    logic       mis;
    assign sz   = d_size_i[2*g +: 2];
    assign lowa = d_addr_i[g*AW +: 3];
    assign mis  = (sz == 2'd1 && lowa[0]) || (sz == 2'd2 && |lowa[1:0]) ||
                  (sz == 2'd3 && |lowa);

    // R3
    read_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
      d_valid_o[g] |-> $past(d_req_i[g] && !d_we_i[g]));

    // R7
    err_excl_valid_chk: assert property (@(posedge clk) disable iff (rst)
      !(d_valid_o[g] && d_err_o[g]));

    // R7
    misaligned_no_write_chk: assert property (@(posedge clk) disable iff (rst)
      (d_req_i[g] && mis) |-> !m_d_we_o[g]);

    // R8
    enable_count_chk: assert property (@(posedge clk) disable iff (rst)
      m_d_we_o[g] |-> ($countones(m_d_be_o[g*LB +: LB]) == (1 << sz)));
  end

endmodule

bind endian_lane_steer elp_checker #(.AW(AW), .NBUS(NBUS), .LB(LB)) i_elp_checker (
  .clk      (clk),
  .rst      (rst),
  .f_req_i  (f_req_i),
  .f_valid_o(f_valid_o),
  .d_req_i  (d_req_i),
  .d_we_i   (d_we_i),
  .d_size_i (d_size_i),
  .d_addr_i (d_addr_i),
  .d_valid_o(d_valid_o),
  .d_err_o  (d_err_o),
  .m_d_we_o (m_d_we_o),
  .m_d_be_o (m_d_be_o),
  .mode_q   (mode_q)
);

// File: tb/test_endian_lane_steer.sv
module test_endian_lane_steer;

  localparam int CLK_P = 10;
  localparam int AW    = 12;
  localparam int NBUS  = 2;
  localparam int DW    = 64;
  localparam int LW    = 128;
  localparam int LB    = 16;
  localparam int LA    = 8;
  localparam int NL    = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic big = 1'b1;
  logic f_req = 1'b0;
  logic [AW-1:0] f_addr = '0;
  logic f_valid;
  logic [LW-1:0] f_insn;
  logic [NBUS-1:0] d_req = '0, d_we = '0;
  logic [2*NBUS-1:0] d_size = '0;
  logic [NBUS*AW-1:0] d_addr = '0;
  logic [NBUS*DW-1:0] d_wdata = '0;
  logic [NBUS-1:0] d_valid, d_err;
  logic [NBUS*DW-1:0] d_rdata;
  logic [LA-1:0] m_f_line;
  logic [LW-1:0] m_f_rdata;
  logic [NBUS*LA-1:0] m_d_line;
  logic [NBUS*LW-1:0] m_d_rdata;
  logic [NBUS-1:0] m_d_we;
  logic [NBUS*LB-1:0] m_d_be;
  logic [NBUS*LW-1:0] m_d_wdata;

  logic [LW-1:0] mem [NL];
  logic [LW-1:0] ref_mem [NL];

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit cur_mode = 0, pend = 0;
  string ctx = "";

  always #(CLK_P/2) clk = ~clk;

  endian_lane_steer #(.AW(AW), .DW(DW), .NBUS(NBUS)) i_endian_lane_steer (
    .clk(clk), .rst(rst), .big_endian_i(big),
    .f_req_i(f_req), .f_addr_i(f_addr), .f_valid_o(f_valid), .f_insn_o(f_insn),
    .d_req_i(d_req), .d_we_i(d_we), .d_size_i(d_size), .d_addr_i(d_addr),
    .d_wdata_i(d_wdata), .d_valid_o(d_valid), .d_err_o(d_err), .d_rdata_o(d_rdata),
    .m_f_line_o(m_f_line), .m_f_rdata_i(m_f_rdata), .m_d_line_o(m_d_line),
    .m_d_rdata_i(m_d_rdata), .m_d_we_o(m_d_we), .m_d_be_o(m_d_be),
    .m_d_wdata_o(m_d_wdata)
  );

  function automatic logic [LW-1:0] init_line(int l);
    logic [LW-1:0] v;
    for (int k = 0; k < LB; k++) v[k*8 +: 8] = (l == 0) ? 8'(8'h10 + k) : 8'((l * 37 + k * 11 + 5) ^ (l >> 2));
    return v;
  endfunction

  // memory model: combinational read, byte-enabled write
  assign m_f_rdata = mem[m_f_line];
  for (genvar g = 0; g < NBUS; g++) begin : g_mrd
    assign m_d_rdata[g*LW +: LW] = mem[m_d_line[g*LA +: LA]];
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NL; l++) mem[l] <= init_line(l);
    end else begin
      for (int g = 0; g < NBUS; g++)
        if (m_d_we[g])
          for (int b = 0; b < LB; b++)
            if (m_d_be[g*LB + b])
              mem[m_d_line[g*LA +: LA]][b*8 +: 8] <= m_d_wdata[g*LW + b*8 +: 8];
    end
  end

  function automatic int lane_of(int k, bit be);
    return be ? (LB - 1 - k) : k;
  endfunction

  function automatic logic [63:0] exp_read(logic [LW-1:0] ln, int off, int n, bit be);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = ln[lane_of(off + i, be)*8 +: 8];
      if (be) r[(n-1-i)*8 +: 8] = b;
      else    r[i*8 +: 8] = b;
    end
    return r;
  endfunction

  function automatic logic [LW-1:0] exp_fetch(logic [LW-1:0] ln, bit be);
    logic [LW-1:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b0, b1;
      b0 = ln[lane_of(2*i, be)*8 +: 8];
      b1 = ln[lane_of(2*i+1, be)*8 +: 8];
      r[i*16 +: 16] = be ? {b0, b1} : {b1, b0};
    end
    return r;
  endfunction

  task automatic chk(bit ok, string deftag, logic [LW-1:0] act, logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", (ctx != "") ? ctx : deftag, act, exp);
    end
  endtask

  task automatic clear_req();
    f_req = 0; d_req = '0; d_we = '0;
  endtask

  // one cycle: predict, advance, compare
  task automatic step();
    bit ev_f; logic [LW-1:0] e_f;
    bit ev[NBUS]; bit ee[NBUS]; logic [63:0] ed[NBUS]; int nb[NBUS];
    bit idle, nxt_mode;
    ev_f = f_req;
    e_f  = exp_fetch(ref_mem[f_addr[AW-1:4]], cur_mode);
    for (int g = 0; g < NBUS; g++) begin
      logic [AW-1:0] a; bit mis;
      a = d_addr[g*AW +: AW];
      nb[g] = 1 << d_size[2*g +: 2];
      mis = (int'(a) % nb[g]) != 0;
      ev[g] = d_req[g] && !d_we[g] && !mis;
      ee[g] = d_req[g] && mis;
      ed[g] = exp_read(ref_mem[a[AW-1:4]], int'(a[3:0]), nb[g], cur_mode);
    end
    for (int g = 0; g < NBUS; g++) begin
      logic [AW-1:0] a;
      a = d_addr[g*AW +: AW];
      if (d_req[g] && d_we[g] && (int'(a) % nb[g]) == 0)
        for (int i = 0; i < nb[g]; i++)
          ref_mem[a[AW-1:4]][lane_of(int'(a[3:0]) + i, cur_mode)*8 +: 8] =
            cur_mode ? d_wdata[g*DW + (nb[g]-1-i)*8 +: 8] : d_wdata[g*DW + i*8 +: 8];
    end
    idle = !f_req && (d_req == '0);
    nxt_mode = (idle && !pend) ? big : cur_mode;
    pend = ev_f || ev[0] || ev[1] || ee[0] || ee[1];
    cur_mode = nxt_mode;
    @(posedge clk); #1;
    chk(f_valid == ev_f, "R1", LW'(f_valid), LW'(ev_f));
    if (ev_f) chk(f_insn == e_f, "R2", f_insn, e_f);
    for (int g = 0; g < NBUS; g++) begin
      logic [63:0] m;
      m = (nb[g] == 8) ? '1 : ((64'd1 << (nb[g]*8)) - 1);
      chk(d_valid[g] == ev[g], "R3", LW'(d_valid[g]), LW'(ev[g]));
      chk(d_err[g] == ee[g], "R7", LW'(d_err[g]), LW'(ee[g]));
      if (ev[g]) begin
        chk((d_rdata[g*DW +: DW] & m) == (ed[g] & m), cur_mode ? "R5" : "R4",
            LW'(d_rdata[g*DW +: DW]), LW'(ed[g]));
        chk((d_rdata[g*DW +: DW] & ~m) == '0, "R3", LW'(d_rdata[g*DW +: DW]), LW'(ed[g]));
      end
    end
  endtask

  task automatic rd(int g, int size, int addr);
    d_req[g] = 1; d_we[g] = 0; d_size[2*g +: 2] = 2'(size); d_addr[g*AW +: AW] = AW'(addr);
  endtask

  task automatic wr(int g, int size, int addr, logic [63:0] v);
    d_req[g] = 1; d_we[g] = 1; d_size[2*g +: 2] = 2'(size); d_addr[g*AW +: AW] = AW'(addr);
    d_wdata[g*DW +: DW] = v;
  endtask

  task automatic idle_n(int n);
    clear_req();
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int l = 0; l < NL; l++) ref_mem[l] = init_line(l);
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R10: reset state
    chk(f_valid == 0 && d_valid == '0 && d_err == '0, "R10", LW'({f_valid, d_valid, d_err}), '0);

    // R10: mode input high but not yet captured, so first access is little-endian
    ctx = "R10"; rd(0, 2, 8); step(); clear_req();
    chk(d_rdata[31:0] == 32'h1B1A1918, "R10", LW'(d_rdata[31:0]), LW'(32'h1B1A1918));
    ctx = "";
    idle_n(2);   // mode captured as big-endian

    // R5: big-endian long, word and byte at 8; R2: fetch slot 0
    rd(0, 2, 8); rd(1, 1, 8); f_req = 1; f_addr = 12'h00B; step(); clear_req();
    chk(d_rdata[31:0] == 32'h17161514, "R5", LW'(d_rdata[31:0]), LW'(32'h17161514));
    chk(d_rdata[64 +: 16] == 16'h1716, "R5", LW'(d_rdata[64 +: 16]), LW'(16'h1716));
    chk(f_insn[15:0] == 16'h1F1E, "R2", LW'(f_insn[15:0]), LW'(16'h1F1E));
    rd(0, 0, 8); step(); clear_req();
    chk(d_rdata[7:0] == 8'h17, "R5", LW'(d_rdata[7:0]), LW'(8'h17));

    // R6: fetch slot and word read agree (big-endian)
    ctx = "R6"; f_req = 1; f_addr = 12'h00F; rd(1, 1, 6); step(); clear_req();
    chk(f_insn[63:48] == d_rdata[64 +: 16], "R6", LW'(f_insn[63:48]), LW'(d_rdata[64 +: 16]));
    ctx = "";

    // R9: back-to-back traffic while the mode input flips
    ctx = "R9";
    for (int i = 0; i < 4; i++) begin
      rd(0, 2, 8);
      if (i == 1) big = 0;
      step();
      chk(d_rdata[31:0] == 32'h17161514, "R9", LW'(d_rdata[31:0]), LW'(32'h17161514));
    end
    ctx = "";
    idle_n(2);   // now little-endian

    // R4: little-endian word/byte at 8
    rd(0, 1, 8); rd(1, 0, 8); step(); clear_req();
    chk(d_rdata[15:0] == 16'h1918, "R4", LW'(d_rdata[15:0]), LW'(16'h1918));
    chk(d_rdata[64 +: 8] == 8'h18, "R4", LW'(d_rdata[64 +: 8]), LW'(8'h18));

    // R6 little-endian
    ctx = "R6"; f_req = 1; f_addr = 12'h003; rd(1, 1, 6); step(); clear_req();
    chk(f_insn[63:48] == d_rdata[64 +: 16], "R6", LW'(f_insn[63:48]), LW'(d_rdata[64 +: 16]));
    ctx = "";

    // R7: misaligned word and long writes leave memory untouched
    ctx = "R7"; wr(0, 1, 9, 64'hFFFF); wr(1, 2, 10, 64'hFFFFFFFF); step(); clear_req();
    rd(0, 2, 8); step(); clear_req();
    chk(d_rdata[31:0] == 32'h1B1A1918, "R7", LW'(d_rdata[31:0]), LW'(32'h1B1A1918));
    ctx = "";

    // R8: byte write changes only its byte
    ctx = "R8"; wr(0, 0, 10, 64'hAB); step(); clear_req();
    rd(0, 2, 8); step(); clear_req();
    chk(d_rdata[31:0] == 32'h1BAB1918, "R8", LW'(d_rdata[31:0]), LW'(32'h1BAB1918));
    ctx = "";

    // R11: both buses at once, different sizes
    ctx = "R11"; rd(0, 3, 16); rd(1, 0, 21); step(); clear_req(); ctx = "";

    // random mixed traffic
    for (int c = 0; c < 4000; c++) begin
      clear_req();
      if ($urandom_range(99) < 5) big = ~big;
      if ($urandom_range(99) >= 20) begin
        f_req = ($urandom_range(99) < 30);
        f_addr = AW'($urandom_range(127));
        for (int g = 0; g < NBUS; g++) begin
          if ($urandom_range(99) < 55) begin
            int sz, a;
            sz = $urandom_range(3);
            a = $urandom_range(127);
            if ($urandom_range(99) < 70) a = a & ~((1 << sz) - 1);
            if ($urandom_range(99) < 40) wr(g, sz, a, {$urandom, $urandom});
            else rd(g, sz, a);
          end
        end
      end
      step();
    end
    idle_n(2);

    // R8: final memory image matches the model
    for (int l = 0; l < 8; l++)
      chk(mem[l] == ref_mem[l], "R8", mem[l], ref_mem[l]);

    finish_run();
  end

endmodule